// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between the memory stage of a 32-bit integer pipeline and a word-wide data memory. A request arrives with a byte address, an access size, a signedness flag, a direction and the source register value. For stores it produces a word-aligned memory address, a four-lane byte-enable mask and write data placed on the correct lanes. For loads it remembers the size, signedness and byte offset while the memory request is outstanding. It then takes the returned word, selects the addressed bytes and widens them to 32 bits.

Lanes are numbered big-endian. Byte offset 0 is the most significant lane, bits 31:24, and is enabled by `mem_be[3]`. Accesses that are not aligned to their own size are flagged and produce no memory request. A fourth size code carries the upper-immediate operation through the same result register. It uses no memory access.

A two-state controller tracks loads. In `ST_IDLE` the block accepts requests. The transition *load issue* (an aligned load request) moves it to `ST_LOAD_WAIT`. The transition *data return* (`mem_rvalid` while waiting) moves it back to `ST_IDLE` and delivers the result. Stores, misaligned requests and upper-immediate requests leave the state at `ST_IDLE`.

Top module: `lsa_top`

## Requirements
- R1: While `rst_n` is low and after reset, `ld_valid` and `ld_data` are 0 and the controller is in `ST_IDLE`.
- R2: `mem_addr` equals `req_addr` with bits 1:0 cleared, combinationally in the same cycle.
- R3: Size codes are 00 byte, 01 halfword, 10 word and 11 upper-immediate. An accepted aligned access drives `mem_be` in the same cycle, with byte offset k mapped to `mem_be[3-k]`:
  - a byte enables exactly that one bit;
  - a halfword at offset 0 enables 1100 and at offset 2 enables 0011;
  - a word enables 1111.
- R4: For a store, `mem_wdata` carries the source register as follows:
  - a byte store copies bits 7:0 into all four lanes;
  - a halfword store copies bits 15:0 into both halves;
  - a word store passes all 32 bits unchanged.
- R5: A halfword with address bit 0 set, or a word with either of bits 1:0 set, is misaligned. `misalign` is then high, `mem_req` is low, `mem_be` is 0000, and no load result follows.
- R6: A load selects its data big-endian:
  - a byte at offset k comes from `mem_rdata[31-8k:24-8k]`;
  - a halfword at offset 0 comes from bits 31:16, and at offset 2 from bits 15:0.
- R7: Signed narrow loads (`req_signed`=1) fill the upper bits with the sign bit of the selected value.
- R8: Unsigned narrow loads (`req_signed`=0) fill the upper bits with zeros.
- R9: When `mem_rvalid` is high in `ST_LOAD_WAIT`, `ld_valid` is high for exactly the next cycle, with the result in `ld_data`. `ld_data` holds its value until the next result.
- R10: An upper-immediate request (size 11) makes no memory request. It raises `ld_valid` in the next cycle with `ld_data` = {`req_wdata[15:0]`, 16'h0}, whatever the value of `req_write`.
- R11: While a load is outstanding, a new request is ignored: `mem_req` and `misalign` stay low and no result follows from it. A `mem_rvalid` seen in `ST_IDLE` produces no result.
- R12: A word load returns all 32 bits of `mem_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 upper-immediate |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Source register value (upper-immediate constant in bits 15:0) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables, bit 3 = lowest address |
| mem_wdata | output | 32 | Lane-placed store data |
| misalign | output | 1 | Accepted request is misaligned |
| mem_rvalid | input | 1 | Returned memory word is valid |
| mem_rdata | input | 32 | Returned memory word |
| ld_valid | output | 1 | Load or upper-immediate result strobe |
| ld_data | output | 32 | Extended result |

## Verification
Stores are driven at every byte offset and at both halfword offsets. The source value has distinct bytes, so a swapped lane or a little-endian mask shows up as a wrong enable bit or a wrong replicated byte. Loads are run against two returned words: one has sign bits set in alternate bytes, the other has a positive upper half and a negative lower half. Each offset is read both signed and unsigned, which separates a lane-selection error from an extension error. Misaligned offsets, requests presented during an outstanding load, stray return strobes in idle, zero-wait returns and upper-immediate requests with both directions exercise the controller's transitions and the cases where nothing may happen.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_UPPER = 2'b11
    } acc_size_t;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_WAIT = 1'b1
    } ld_state_t;

    typedef struct packed {
        acc_size_t  size;
        logic       sgn;
        logic [1:0] off;
    } ld_tag_t;

endpackage

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t               size,
    input  logic [1:0]              off,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W/8-1:0]     be,
    output logic [DATA_W-1:0]       lane_data,
    output logic                    misaligned
);
    localparam int LANES = DATA_W / 8;

    assign misaligned = ((size == SZ_HALF) && off[0]) ||
                        ((size == SZ_WORD) && (off != 2'b00));

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int         HI   = DATA_W - 1 - 8 * k;
        localparam bit         EVEN = ((k % 2) == 0);
        localparam logic [1:0] OFF  = 2'(k);
        localparam logic       PAIR = 1'(k / 2);

        assign lane_data[HI -: 8] =
            (size == SZ_BYTE) ? wdata[7:0] :
            (size == SZ_HALF) ? (EVEN ? wdata[15:8] : wdata[7:0]) :
                                wdata[HI -: 8];

        assign be[LANES-1-k] = !misaligned && (
            ((size == SZ_BYTE) && (off == OFF)) ||
            ((size == SZ_HALF) && (off[1] == PAIR)) ||
            (size == SZ_WORD));
    end

endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rdata,
    input  ld_tag_t           tag,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  sel_byte;
    logic [15:0] sel_half;

    always_comb begin
        sel_byte = rdata[DATA_W - 1 - 8 * int'(tag.off) -: 8];
        sel_half = tag.off[1] ? rdata[15:0] : rdata[31:16];
        unique case (tag.size)
            SZ_BYTE: result = {{(DATA_W-8){tag.sgn & sel_byte[7]}}, sel_byte};
            SZ_HALF: result = {{(DATA_W-16){tag.sgn & sel_half[15]}}, sel_half};
            default: result = rdata;
        endcase
    end

endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic                  req_signed,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic                  misalign,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  ld_valid,
    output logic [DATA_W-1:0]     ld_data
);
    localparam int LANES = DATA_W / 8;
    localparam int HALF  = DATA_W / 2;

    ld_state_t           st_q, st_d;
    ld_tag_t             pend_q;
    acc_size_t           sz;
    logic [LANES-1:0]    be_c;
    logic                mis_c;
    logic [DATA_W-1:0]   ext_c;
    logic                accept, is_upper, load_issue, upper_issue, data_return;

    assign sz          = acc_size_t'(req_size);
    assign is_upper    = (sz == SZ_UPPER);
    assign accept      = req_valid && (st_q == ST_IDLE);
    assign misalign    = accept && mis_c;
    assign mem_req     = accept && !mis_c && !is_upper;
    assign mem_we      = mem_req && req_write;
    assign mem_be      = mem_req ? be_c : '0;
    assign mem_addr    = {req_addr[ADDR_W-1:2], 2'b00};
    assign load_issue  = mem_req && !req_write;
    assign upper_issue = accept && is_upper;
    assign data_return = (st_q == ST_LOAD_WAIT) && mem_rvalid;

    lsa_store_lane #(.DATA_W(DATA_W)) store_i (
        .size       (sz),
        .off        (req_addr[1:0]),
        .wdata      (req_wdata),
        .be         (be_c),
        .lane_data  (mem_wdata),
        .misaligned (mis_c)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) load_i (
        .rdata  (mem_rdata),
        .tag    (pend_q),
        .result (ext_c)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:      if (load_issue)  st_d = ST_LOAD_WAIT;
            ST_LOAD_WAIT: if (data_return) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
            pend_q   <= '0;
        end else begin
            ld_valid <= 1'b0;
            if (load_issue)
                pend_q <= '{size: sz, sgn: req_signed, off: req_addr[1:0]};
            if (data_return) begin
                ld_valid <= 1'b1;
                ld_data  <= ext_c;
            end else if (upper_issue) begin
                ld_valid <= 1'b1;
                ld_data  <= {req_wdata[HALF-1:0], {HALF{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/lsa_checker.sv
module lsa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        req_valid,
    input logic [1:0]  req_size,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        misalign,
    input logic        mem_rvalid,
    input logic        ld_valid
);
    p_misalign_no_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_be == 4'b0000 && !mem_req));

    p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_byte_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'b00) |-> ($countones(mem_be) == 1));

    p_word_all_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && req_size == 2'b10) |-> (mem_be == 4'b1111));

    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_req && !misalign));

    p_return_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_rvalid) |=> ld_valid);

    p_idle_return_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mem_rvalid && !(req_valid && req_size == 2'b11)) |=> !ld_valid);
endmodule

bind lsa_top lsa_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (st_q),
    .req_valid  (req_valid),
    .req_size   (req_size),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .misalign   (misalign),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid)
);

// File: tb/lsa_top_tb_top.sv
`timescale 1ns/1ps
module lsa_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_signed, mem_rvalid;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata, mem_rdata;
    logic        mem_req, mem_we, misalign, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit          m_busy = 0;
    int          m_size, m_off;
    bit          m_sgn;
    bit          m_ld_valid = 0;
    logic [31:0] m_ld_data = '0;
    string       m_ld_tag = "R1";

    always #2.5 clk = ~clk;

    lsa_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .misalign(misalign), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] load_value(logic [31:0] w, int size, int off, bit sgn);
        logic [7:0] b [4];
        logic [31:0] v;
        for (int i = 0; i < 4; i++) b[i] = w[31-8*i -: 8];
        if (size == 0) begin
            v = {24'h0, b[off]};
            if (sgn && b[off][7]) v = v | 32'hFFFF_FF00;
        end else if (size == 1) begin
            v = {16'h0, b[off], b[off+1]};
            if (sgn && b[off][7]) v = v | 32'hFFFF_0000;
        end else begin
            v = w;
        end
        return v;
    endfunction

    task automatic cyc(bit v, bit wr, int size, bit sgn, logic [31:0] a,
                       logic [31:0] wd, bit rv, logic [31:0] rd);
        bit acc, mis, rq;
        logic [3:0] be;
        logic [31:0] wexp;
        int off;
        req_valid = v; req_write = wr; req_size = 2'(size); req_signed = sgn;
        req_addr = a; req_wdata = wd; mem_rvalid = rv; mem_rdata = rd;
        #1;
        off  = int'(a[1:0]);
        acc  = v && !m_busy;
        mis  = acc && ((size == 1 && off[0]) || (size == 2 && off != 0));
        rq   = acc && !mis && size != 3;
        be   = 4'b0000;
        if (rq) begin
            if (size == 0)      be = 4'b1000 >> off;
            else if (size == 1) be = (off == 0) ? 4'b1100 : 4'b0011;
            else                be = 4'b1111;
        end
        chk("R2", "mem_addr", mem_addr, {a[31:2], 2'b00});
        chk(m_busy ? "R11" : "R5", "misalign", 32'(misalign), 32'(mis));
        chk(m_busy ? "R11" : "R5", "mem_req", 32'(mem_req), 32'(rq));
        chk(mis ? "R5" : "R3", "mem_be", 32'(mem_be), 32'(be));
        chk("R4", "mem_we", 32'(mem_we), 32'(rq && wr));
        if (rq && wr) begin
            if (size == 0)      wexp = {4{wd[7:0]}};
            else if (size == 1) wexp = {2{wd[15:0]}};
            else                wexp = wd;
            chk("R4", "mem_wdata", mem_wdata, wexp);
        end
        chk(m_ld_tag, "ld_valid", 32'(ld_valid), 32'(m_ld_valid));
        chk(m_ld_tag, "ld_data", ld_data, m_ld_data);
        @(posedge clk);
        m_ld_valid = 0;
        if (m_busy && rv) begin
            m_busy = 0;
            m_ld_valid = 1;
            m_ld_data = load_value(rd, m_size, m_off, m_sgn);
            if (m_size == 2)      m_ld_tag = "R12";
            else if (m_sgn)       m_ld_tag = "R7";
            else                  m_ld_tag = "R8";
        end else if (!m_busy && v) begin
            if (size == 3) begin
                m_ld_valid = 1;
                m_ld_data = {wd[15:0], 16'h0};
                m_ld_tag = "R10";
            end else if (!mis && !wr) begin
                m_busy = 1; m_size = size; m_off = off; m_sgn = sgn;
            end
        end else begin
            m_ld_tag = (rv || m_busy) ? "R11" : "R9";
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 32'h0, 32'h0, 0, 32'h0);
    endtask

    initial begin
        logic [31:0] pats [2];
        pats[0] = 32'h8F7E_C341;
        pats[1] = 32'h7F01_8002;
        rst_n = 1'b0;
        req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
        req_addr = 0; req_wdata = 0; mem_rvalid = 0; mem_rdata = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "ld_valid in reset", 32'(ld_valid), 32'h0);
        chk("R1", "ld_data in reset", ld_data, 32'h0);
        chk("R1", "mem_req in reset", 32'(mem_req), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3 R4: stores at every offset and size
        for (int o = 0; o < 4; o++) cyc(1, 1, 0, 0, 32'h1000_0040 + o, 32'hA1B2_C3D4, 0, 0);
        cyc(1, 1, 1, 0, 32'h2000_0010, 32'h5566_7788, 0, 0);
        cyc(1, 1, 1, 0, 32'h2000_0012, 32'h5566_7788, 0, 0);
        cyc(1, 1, 2, 0, 32'h2000_0014, 32'hDEAD_BEEF, 0, 0);

        // R5: misaligned halfwords and words, stores and loads
        for (int o = 1; o < 4; o++) begin
            cyc(1, 1, 2, 0, 32'h3000_0000 + o, 32'h1234_5678, 0, 0);
            cyc(1, 0, 2, 1, 32'h3000_0000 + o, 32'h0, 0, 0);
            if (o != 2) cyc(1, 0, 1, 0, 32'h3000_0000 + o, 32'h0, 0, 0);
        end
        idle(1);

        // R6 R7 R8: narrow loads, wait cycle holds an ignored request (R11)
        for (int p = 0; p < 2; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int o = 0; o < 4; o++) begin
                    cyc(1, 0, 0, s[0], 32'h4000_0100 + o, 0, 0, 0);
                    cyc(1, 1, 2, 0, 32'h4000_0201, 32'hFFFF_FFFF, 0, 0);
                    cyc(0, 0, 0, 0, 0, 0, 1, pats[p]);
                end
                for (int o = 0; o < 4; o += 2) begin
                    cyc(1, 0, 1, s[0], 32'h4000_0300 + o, 0, 0, 0);
                    cyc(0, 0, 0, 0, 0, 0, 1, pats[p]);
                end
            end
            // R12 word load
            cyc(1, 0, 2, 1, 32'h4000_0400, 0, 0, 0);
            cyc(0, 0, 0, 0, 0, 0, 1, pats[p]);
        end
        idle(1);

        // R9: result held after strobe
        idle(2);

        // R10: upper-immediate, both directions
        cyc(1, 0, 3, 0, 32'h0000_0003, 32'h0000_ABCD, 0, 0);
        cyc(1, 1, 3, 1, 32'h0000_0001, 32'h9999_8001, 0, 0);
        idle(1);

        // R11: stray return strobes in idle
        cyc(0, 0, 0, 0, 0, 0, 1, 32'hCAFE_F00D);
        cyc(1, 1, 0, 0, 32'h5000_0002, 32'h0000_0077, 1, 32'h1111_1111);
        idle(1);

        // R9: back-to-back loads with return in the very next cycle
        cyc(1, 0, 1, 1, 32'h6000_0002, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h0123_8765);
        cyc(1, 0, 0, 0, 32'h6000_0001, 0, 0, 0);
        cyc(1, 0, 0, 0, 32'h6000_0002, 0, 1, 32'h0123_8765);
        idle(3);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got %0d exp %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule